// File: doc/BRIEF.md
# Mode-Selectable Combinational Restoring Divider

This block divides an integer dividend by an integer divisor in pure combinational logic. No clock is involved. A chain of restoring stages works through the dividend from its most significant bit down. Each stage shifts one dividend bit into a partial remainder and tries to subtract the divisor. It keeps the difference only when that difference is not negative, and the outcome of that test is the quotient bit for the stage. The dividend and the divisor each have their own width parameter. The quotient is as wide as the dividend, and the remainder is as wide as the divisor.

A single mode input selects how the operands are read. In unsigned mode they are plain binary magnitudes. In signed mode they are two's-complement values. Each negative operand is turned into its magnitude before the stage chain. After the chain, the results are re-signed so that the quotient truncates toward zero and the remainder takes the sign of the dividend. The surrounding logic registers the outputs once they have settled.

A zero divisor is outside the defined range, and the outputs are then unspecified. The signed case of the most negative dividend divided by -1 overflows the quotient width and also has no defined result.

Top module: `mdiv_comb`

## Requirements
- R1: With `signed_mode` = 0 and a nonzero divisor, `quotient` equals the integer quotient of `dividend` by `divisor`, rounded down, with both operands read as unsigned.
- R2: With `signed_mode` = 0 and a nonzero divisor, `remainder` equals `dividend` modulo `divisor`, so it is always less than the divisor.
- R3: With `signed_mode` = 1, both operands are read as two's complement (the MSB is the sign bit). For a nonzero divisor and no overflow, `quotient` is the true quotient truncated toward zero, for example -7 / 2 gives -3.
- R4: With `signed_mode` = 1, a nonzero `remainder` has the sign of `dividend`, and its magnitude is less than the magnitude of `divisor`. For example, -7 / 2 gives a remainder of -1.
- R5: In both modes, for a nonzero divisor and outside the signed overflow case, quotient × divisor + remainder equals the dividend, each value taken in its mode's interpretation.
- R6: The quotient uses the full dividend width and the remainder uses the divisor width, independently. With an 8-bit dividend, unsigned 255 / 1 gives 255, and signed -128 / 1 gives -128 (8'h80).
- R7: The same bit patterns give different results in the two modes. 8'hF9 / 2 gives quotient 8'h7C and remainder 1 in unsigned mode, and quotient 8'hFD and remainder all ones (-1) in signed mode.
- R8: The outputs follow any change of `dividend`, `divisor` or `signed_mode` with no clock edge.
- R9: In signed mode a negative operand is converted to a nonzero magnitude, so the most negative value of either operand is divided correctly. For example, -128 / 2 gives -64, and 100 / -32 gives -3 with remainder 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | DVD_W | Dividend operand |
| divisor | input | DVS_W | Divisor operand (nonzero for a defined result) |
| signed_mode | input | 1 | 1 = two's-complement division, 0 = unsigned division |
| quotient | output | DVD_W | Quotient, truncated toward zero |
| remainder | output | DVS_W | Remainder, carrying the dividend's sign in signed mode |

## Verification
Whenever the inputs are in the defined range, the embedded checks test the reconstruction identity, the sign and bound of the remainder, and the bound of each stage's partial remainder. They also check that a negative operand always has a nonzero magnitude. Those properties cannot tell whether the exact quotient is right, how truncation is rounded, or whether the two modes read the same bits differently. Only the bench can show those. It sweeps every dividend against every nonzero divisor in both modes, with the dividend and divisor at different widths, and compares the results with arithmetic reference values. Directed cases cover the widest results, the most negative operands and how quickly the outputs follow the inputs.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mdiv_mode_e;
endpackage

// File: rtl/mdiv_operand_mag.sv
module mdiv_operand_mag #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  logic         as_signed,
  output logic [W-1:0] mag,
  output logic         is_neg
);
  always_comb begin
    is_neg = as_signed & val[W-1];
    mag    = is_neg ? (~val + W'(1)) : val;
  end

  always_comb begin
    // R9
    mag_nonzero_chk: assert (!is_neg || (mag != '0))
      else $error("negative operand produced zero magnitude");
  end
endmodule

// File: rtl/mdiv_stage.sv
module mdiv_stage #(
  parameter int VW = 8
) (
  input  logic [VW-1:0] rem_in,
  input  logic          din_bit,
  input  logic [VW-1:0] dvs,
  output logic [VW-1:0] rem_out,
  output logic          qbit
);
  localparam int PW = VW + 1;
  localparam int DW2 = VW + 2;

  logic [PW-1:0]  shifted;
  logic [DW2-1:0] trial;

  always_comb begin
    shifted = {rem_in, din_bit};
    trial   = {1'b0, shifted} - {2'b00, dvs};
    qbit    = ~trial[DW2-1];
    rem_out = qbit ? trial[VW-1:0] : shifted[VW-1:0];
  end

  always_comb begin
    // R2
    stage_rem_bound_chk: assert (!((dvs != '0) && (rem_in < dvs)) || (rem_out < dvs))
      else $error("partial remainder escaped divisor bound");
    // R5
    stage_rem_shrink_chk: assert (!((dvs != '0) && (rem_in < dvs)) || ({1'b0, rem_out} <= shifted))
      else $error("partial remainder grew in a stage");
  end
endmodule

// File: rtl/mdiv_array.sv
module mdiv_array #(
  parameter int DW = 8,
  parameter int VW = 8
) (
  input  logic [DW-1:0] dvd_mag,
  input  logic [VW-1:0] dvs_mag,
  output logic [DW-1:0] q_mag,
  output logic [VW-1:0] r_mag
);
  logic [DW:0][VW-1:0] rem_chain;

  assign rem_chain[0] = '0;

  for (genvar s = 0; s < DW; s++) begin : g_stage
    mdiv_stage #(.VW(VW)) u_stage (
      .rem_in (rem_chain[s]),
      .din_bit(dvd_mag[DW-1-s]),
      .dvs    (dvs_mag),
      .rem_out(rem_chain[s+1]),
      .qbit   (q_mag[DW-1-s])
    );
  end

  assign r_mag = rem_chain[DW];
endmodule

// File: rtl/mdiv_sign_fix.sv
module mdiv_sign_fix #(
  parameter int DW = 8,
  parameter int VW = 8
) (
  input  logic [DW-1:0] q_mag,
  input  logic [VW-1:0] r_mag,
  input  logic          dvd_neg,
  input  logic          dvs_neg,
  output logic [DW-1:0] q_out,
  output logic [VW-1:0] r_out
);
  logic q_flip;

  always_comb begin
    q_flip = dvd_neg ^ dvs_neg;
    q_out  = q_flip  ? (~q_mag + DW'(1)) : q_mag;
    r_out  = dvd_neg ? (~r_mag + VW'(1)) : r_mag;
  end
endmodule

// File: rtl/mdiv_comb.sv
module mdiv_comb
  import mdiv_pkg::*;
#(
  parameter int DVD_W = 8,
  parameter int DVS_W = 8
) (
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  input  logic             signed_mode,
  output logic [DVD_W-1:0] quotient,
  output logic [DVS_W-1:0] remainder
);
  localparam int SW = DVD_W + DVS_W + 1;

  logic             as_signed;
  logic [DVD_W-1:0] dvd_mag;
  logic [DVS_W-1:0] dvs_mag;
  logic             dvd_neg;
  logic             dvs_neg;
  logic [DVD_W-1:0] q_mag;
  logic [DVS_W-1:0] r_mag;

  assign as_signed = (mdiv_mode_e'(signed_mode) == MODE_SIGNED);

  mdiv_operand_mag #(.W(DVD_W)) u_dvd_mag (
    .val      (dividend),
    .as_signed(as_signed),
    .mag      (dvd_mag),
    .is_neg   (dvd_neg)
  );

  mdiv_operand_mag #(.W(DVS_W)) u_dvs_mag (
    .val      (divisor),
    .as_signed(as_signed),
    .mag      (dvs_mag),
    .is_neg   (dvs_neg)
  );

  mdiv_array #(.DW(DVD_W), .VW(DVS_W)) u_array (
    .dvd_mag(dvd_mag),
    .dvs_mag(dvs_mag),
    .q_mag  (q_mag),
    .r_mag  (r_mag)
  );

  mdiv_sign_fix #(.DW(DVD_W), .VW(DVS_W)) u_fix (
    .q_mag  (q_mag),
    .r_mag  (r_mag),
    .dvd_neg(dvd_neg),
    .dvs_neg(dvs_neg),
    .q_out  (quotient),
    .r_out  (remainder)
  );

  // Result checks against the operands.
  logic                 ovf_case;
  logic                 in_range;
  logic [SW-1:0]        recon_u;
  logic signed [SW-1:0] recon_s;
  logic signed [SW-1:0] dvd_s;
  logic [DVS_W-1:0]     r_abs;

  always_comb begin
    ovf_case = as_signed && (dividend == {1'b1, {(DVD_W-1){1'b0}}}) && (&divisor);
    in_range = (divisor != '0) && !ovf_case;
    recon_u  = SW'(quotient) * SW'(divisor) + SW'(remainder);
    recon_s  = SW'($signed(quotient)) * SW'($signed(divisor)) + SW'($signed(remainder));
    dvd_s    = SW'($signed(dividend));
    r_abs    = remainder[DVS_W-1] ? (~remainder + DVS_W'(1)) : remainder;
  end

  always_comb begin
    // R5
    recon_unsigned_chk: assert (!(in_range && !as_signed) || (recon_u == SW'(dividend)))
      else $error("unsigned reconstruction mismatch");
    // R5
    recon_signed_chk: assert (!(in_range && as_signed) || (recon_s == dvd_s))
      else $error("signed reconstruction mismatch");
    // R4
    rem_sign_chk: assert (!(in_range && as_signed && (remainder != '0)) ||
                          (remainder[DVS_W-1] == dividend[DVD_W-1]))
      else $error("signed remainder sign differs from dividend");
    // R4
    rem_mag_chk: assert (!(in_range && as_signed) || (r_abs < dvs_mag))
      else $error("signed remainder magnitude not below divisor magnitude");
    // R2
    rem_unsigned_chk: assert (!(in_range && !as_signed) || (remainder < divisor))
      else $error("unsigned remainder not below divisor");
  end
endmodule

// File: tb/tb_mdiv_comb.sv
module tb_mdiv_comb;
  localparam int DW = 8;
  localparam int VW = 6;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk;
  logic rst_n;
  logic [DW-1:0] dividend;
  logic [VW-1:0] divisor;
  logic          signed_mode;
  logic [DW-1:0] quotient;
  logic [VW-1:0] remainder;

  int checks;
  int failures;
  bit done;

  mdiv_comb #(.DVD_W(DW), .DVS_W(VW)) dut (
    .dividend   (dividend),
    .divisor    (divisor),
    .signed_mode(signed_mode),
    .quotient   (quotient),
    .remainder  (remainder)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int sx_dvd(input logic [DW-1:0] v);
    return v[DW-1] ? int'(v) - (1 << DW) : int'(v);
  endfunction

  function automatic int sx_dvs(input logic [VW-1:0] v);
    return v[VW-1] ? int'(v) - (1 << VW) : int'(v);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (dvd=%h dvs=%h mode=%0b)",
               req, act, exp, dividend, divisor, signed_mode);
    end
  endtask

  task automatic apply(input logic [DW-1:0] a, input logic [VW-1:0] b, input logic m);
    @(negedge clk);
    dividend    = a;
    divisor     = b;
    signed_mode = m;
    #1;
  endtask

  initial begin
    dividend    = '0;
    divisor     = VW'(1);
    signed_mode = 1'b0;
    rst_n       = 1'b0;
    checks      = 0;
    failures    = 0;
    done        = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Exhaustive sweep, unsigned mode: R1, R2
    for (int i = 0; i < (1 << DW); i++) begin
      for (int j = 1; j < (1 << VW); j++) begin
        apply(DW'(i), VW'(j), 1'b0);
        check("R1", int'(quotient), i / j);
        check("R2", int'(remainder), i % j);
      end
    end

    // Exhaustive sweep, signed mode: R3, R4 (overflow case skipped)
    for (int i = 0; i < (1 << DW); i++) begin
      for (int j = 1; j < (1 << VW); j++) begin
        int a;
        int b;
        a = sx_dvd(DW'(i));
        b = sx_dvs(VW'(j));
        if ((a / b) <= ((1 << (DW-1)) - 1)) begin
          apply(DW'(i), VW'(j), 1'b1);
          check("R3", sx_dvd(quotient), a / b);
          check("R4", sx_dvs(remainder), a % b);
        end
      end
    end

    // R5: reconstruction identity on directed signed and unsigned cases
    apply(DW'(-100), VW'(7), 1'b1);
    check("R5", sx_dvd(quotient) * 7 + sx_dvs(remainder), -100);
    apply(DW'(201), VW'(13), 1'b0);
    check("R5", int'(quotient) * 13 + int'(remainder), 201);

    // R6: full-width quotient independent of divisor width
    apply(8'hFF, VW'(1), 1'b0);
    check("R6", int'(quotient), 255);
    check("R6", int'(remainder), 0);
    apply(8'h80, VW'(1), 1'b1);
    check("R6", int'(quotient), 8'h80);

    // R7: same bits, different modes
    apply(8'hF9, VW'(2), 1'b0);
    check("R7", int'(quotient), 8'h7C);
    check("R7", int'(remainder), 1);
    apply(8'hF9, VW'(2), 1'b1);
    check("R7", int'(quotient), 8'hFD);
    check("R7", int'(remainder), 6'h3F);

    // R8: outputs follow inputs between clock edges
    @(negedge clk);
    #2;
    dividend = 8'd50; divisor = VW'(5); signed_mode = 1'b0;
    #1;
    check("R8", int'(quotient), 10);
    dividend = 8'd51;
    #1;
    check("R8", int'(remainder), 1);
    signed_mode = 1'b1; dividend = DW'(-51);
    #1;
    check("R8", sx_dvd(quotient), -10);

    // R9: most negative operands
    apply(8'h80, VW'(2), 1'b1);
    check("R9", sx_dvd(quotient), -64);
    apply(DW'(100), 6'h20, 1'b1);
    check("R9", sx_dvd(quotient), -3);
    check("R9", sx_dvs(remainder), 4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule